// File: doc/BRIEF.md
# Tagged Reservation Station Issue Core

This block schedules arithmetic operations out of order. Decoded operations enter a small in-order queue. From the head of that queue, one operation per cycle moves into a free reservation station of the matching class: adder stations for add and subtract, multiplier stations for multiply and divide. On the way in, each source operand either copies its current register value or records the tag of the station that will produce it. The destination register then records the new station's tag as its pending producer. This renaming removes write-after-read and write-after-write stalls.

A station starts on its functional unit once both operands are present. Each unit is a non-pipelined, fixed-latency model. There is one adder unit with a 2-cycle latency and one multiplier unit with a 4-cycle latency. All results return on a single broadcast bus that carries a tag and a value. In the cycle of a broadcast, every waiting station captures the value. A register is written only if its pending producer is still the broadcasting station. A debug read port exposes each register's value and its pending tag.

Top module: `rs_issue_core`

## Requirements
- R1: After reset, register i holds the value i, no register has a pending producer (tag 0), the input queue is ready and the result bus is idle.
- R2: Operations leave the queue in arrival order, at most one per cycle. The queue holds 4 entries, and `in_ready` falls when it is full. The head waits while no station of its class is free, so a burst of multiplies stalls the input.
- R3: On issue, the destination register's pending tag becomes the tag of the station taken. Adder stations carry tags 1 to 3 and multiplier stations tags 4 and 5, and the lowest free one is taken first. A source whose register has no pending producer copies the register value; otherwise it waits on that producer's tag.
- R4: A station starts only when both operands are present. Into an idle core, an add accepted at clock edge P is broadcast in the cycle after edge P+3 and a multiply in the cycle after edge P+5.
- R5: Stations waiting on a broadcast tag capture its value in that cycle, so chains of dependent operations produce the same register contents as in-order execution.
- R6: When two in-flight operations target one register, only the later-issued one writes it. An older broadcast whose tag no longer matches the register's pending tag leaves the register unchanged.
- R7: The `in_op` encoding is 0 = add, 1 = subtract (src1 - src2), 2 = multiply (low 16 bits), 3 = unsigned divide (src1 / src2, all ones when src2 is zero). Registers and results are 16 bits wide.
- R8: When both units finish in the same cycle, the multiplier result is broadcast first and the adder result follows in the next cycle.
- R9: A station is released at its broadcast. An operation issuing at that same edge that reads the broadcast tag takes the bus value directly.
- R10: An operation whose destination is also one of its sources reads the producer that was pending before its own issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New operation offered |
| in_ready | output | 1 | Queue can accept an operation |
| in_op | input | 2 | Operation code |
| in_dst | input | 3 | Destination register |
| in_src1 | input | 3 | First source register |
| in_src2 | input | 3 | Second source register |
| rd_addr | input | 3 | Debug register select |
| rd_value | output | 16 | Selected register value |
| rd_tag | output | 3 | Selected register pending producer tag |
| cdb_valid | output | 1 | Result bus carries a result |
| cdb_tag | output | 3 | Tag of broadcasting station |
| cdb_value | output | 16 | Broadcast result value |

## Verification
The hardest situation to reach from the ports is the exact-edge coincidence. One case is an issue that lands on the same edge as the broadcast of one of its sources. The other is both units finishing in the same cycle. Random traffic reaches these only by chance. Directed sequences therefore place them by counting edges from the moment an operation is accepted into an otherwise idle core. For example, a multiply is offered, then an add is offered exactly two cycles later so that the two units finish together. Long random runs with mixed classes, dependencies and reused destinations then compare every register against an in-order model after the core drains.

// File: rtl/rs_issue_core.sv
module rs_issue_core #(
  parameter int DW = 16,
  parameter int NREG = 8,
  parameter int NA = 3,
  parameter int NM = 2,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 4,
  parameter int QD = 4,
  localparam int RW = $clog2(NREG),
  localparam int NS = NA + NM,
  localparam int TW = $clog2(NS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_op,
  input  logic [RW-1:0] in_dst,
  input  logic [RW-1:0] in_src1,
  input  logic [RW-1:0] in_src2,
  input  logic [RW-1:0] rd_addr,
  output logic [DW-1:0] rd_value,
  output logic [TW-1:0] rd_tag,
  output logic          cdb_valid,
  output logic [TW-1:0] cdb_tag,
  output logic [DW-1:0] cdb_value
);
  localparam int QW = $clog2(QD);
  localparam int CW = $clog2(LAT_MUL + 1);

  logic [DW-1:0] regs [NREG];
  logic [TW-1:0] qi   [NREG];

  logic [1:0]    q_op  [QD];
  logic [RW-1:0] q_dst [QD];
  logic [RW-1:0] q_s1  [QD];
  logic [RW-1:0] q_s2  [QD];
  logic [QW-1:0] q_head, q_tail;
  logic [QW:0]   q_cnt;

  logic          s_busy [NS+1];
  logic          s_exec [NS+1];
  logic [1:0]    s_op   [NS+1];
  logic [TW-1:0] s_qj   [NS+1];
  logic [TW-1:0] s_qk   [NS+1];
  logic [DW-1:0] s_vj   [NS+1];
  logic [DW-1:0] s_vk   [NS+1];

  logic          a_act, m_act;
  logic [CW-1:0] a_cnt, m_cnt;
  logic [TW-1:0] a_tag, m_tag;
  logic [DW-1:0] a_res, m_res;

  logic [1:0]    h_op;
  logic [RW-1:0] h_dst, h_s1, h_s2;
  logic          push, issue, is_mul;
  logic [TW-1:0] iss_tag, a_pick, m_pick;
  logic [TW-1:0] t1, t2;
  logic [DW-1:0] v1, v2;
  logic          a_done, m_done, a_free, m_free, a_start, m_start;

  assign h_op   = q_op[q_head];
  assign h_dst  = q_dst[q_head];
  assign h_s1   = q_s1[q_head];
  assign h_s2   = q_s2[q_head];
  assign is_mul = h_op[1];
  assign in_ready = q_cnt < (QW+1)'(QD);
  assign push   = in_valid && in_ready;
  assign issue  = (q_cnt != '0) && (iss_tag != '0);

  assign rd_value = regs[rd_addr];
  assign rd_tag   = qi[rd_addr];

  assign a_done    = a_act && (a_cnt == '0);
  assign m_done    = m_act && (m_cnt == '0);
  assign cdb_valid = a_done || m_done;
  assign cdb_tag   = m_done ? m_tag : a_tag;
  assign cdb_value = m_done ? m_res : a_res;
  assign a_free    = !a_act || (a_done && !m_done);
  assign m_free    = !m_act || m_done;
  assign a_start   = a_free && (a_pick != '0);
  assign m_start   = m_free && (m_pick != '0);

  always_comb begin
    iss_tag = '0;
    for (int i = NS; i >= 1; i--)
      if (!s_busy[i] && ((i > NA) == is_mul)) iss_tag = TW'(i);
    a_pick = '0;
    for (int i = NA; i >= 1; i--)
      if (s_busy[i] && !s_exec[i] && s_qj[i] == '0 && s_qk[i] == '0) a_pick = TW'(i);
    m_pick = '0;
    for (int i = NS; i >= NA + 1; i--)
      if (s_busy[i] && !s_exec[i] && s_qj[i] == '0 && s_qk[i] == '0) m_pick = TW'(i);
  end

  always_comb begin
    t1 = qi[h_s1];
    v1 = regs[h_s1];
    if (t1 != '0) begin
      v1 = cdb_value;
      if (cdb_valid && cdb_tag == t1) t1 = '0;
    end
    t2 = qi[h_s2];
    v2 = regs[h_s2];
    if (t2 != '0) begin
      v2 = cdb_value;
      if (cdb_valid && cdb_tag == t2) t2 = '0;
    end
  end

  function automatic logic [DW-1:0] f_add(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    return op[0] ? a - b : a + b;
  endfunction

  function automatic logic [DW-1:0] f_mul(input logic [1:0] op, input logic [DW-1:0] a, input logic [DW-1:0] b);
    if (!op[0]) return a * b;
    if (b == '0) return '1;
    return a / b;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_head <= '0;
      q_tail <= '0;
      q_cnt  <= '0;
    end else begin
      if (push) begin
        q_op[q_tail]  <= in_op;
        q_dst[q_tail] <= in_dst;
        q_s1[q_tail]  <= in_src1;
        q_s2[q_tail]  <= in_src2;
        q_tail <= q_tail + 1'b1;
      end
      if (issue) q_head <= q_head + 1'b1;
      q_cnt <= q_cnt + (QW+1)'(push) - (QW+1)'(issue);
    end
  end

  always_ff @(posedge clk) begin
    for (int r = 0; r < NREG; r++) begin
      if (!rst_n) begin
        regs[r] <= DW'(r);
        qi[r]   <= '0;
      end else begin
        if (cdb_valid && qi[r] == cdb_tag) regs[r] <= cdb_value;
        if (issue && h_dst == RW'(r)) qi[r] <= iss_tag;
        else if (cdb_valid && qi[r] == cdb_tag) qi[r] <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i <= NS; i++) begin
      if (!rst_n) begin
        s_busy[i] <= 1'b0;
        s_exec[i] <= 1'b0;
        s_op[i]   <= '0;
        s_qj[i]   <= '0;
        s_qk[i]   <= '0;
        s_vj[i]   <= '0;
        s_vk[i]   <= '0;
      end else if (issue && iss_tag == TW'(i)) begin
        s_busy[i] <= 1'b1;
        s_exec[i] <= 1'b0;
        s_op[i]   <= h_op;
        s_qj[i]   <= t1;
        s_qk[i]   <= t2;
        s_vj[i]   <= v1;
        s_vk[i]   <= v2;
      end else if (cdb_valid && cdb_tag == TW'(i)) begin
        s_busy[i] <= 1'b0;
        s_exec[i] <= 1'b0;
      end else begin
        if ((a_start && a_pick == TW'(i)) || (m_start && m_pick == TW'(i))) s_exec[i] <= 1'b1;
        if (s_busy[i] && cdb_valid && s_qj[i] == cdb_tag) begin
          s_qj[i] <= '0;
          s_vj[i] <= cdb_value;
        end
        if (s_busy[i] && cdb_valid && s_qk[i] == cdb_tag) begin
          s_qk[i] <= '0;
          s_vk[i] <= cdb_value;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_act <= 1'b0;
      a_cnt <= '0;
      a_tag <= '0;
      a_res <= '0;
    end else if (a_start) begin
      a_act <= 1'b1;
      a_cnt <= CW'(LAT_ADD - 1);
      a_tag <= a_pick;
      a_res <= f_add(s_op[a_pick], s_vj[a_pick], s_vk[a_pick]);
    end else if (a_done && !m_done) begin
      a_act <= 1'b0;
    end else if (a_act && a_cnt != '0) begin
      a_cnt <= a_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_act <= 1'b0;
      m_cnt <= '0;
      m_tag <= '0;
      m_res <= '0;
    end else if (m_start) begin
      m_act <= 1'b1;
      m_cnt <= CW'(LAT_MUL - 1);
      m_tag <= m_pick;
      m_res <= f_mul(s_op[m_pick], s_vj[m_pick], s_vk[m_pick]);
    end else if (m_done) begin
      m_act <= 1'b0;
    end else if (m_act && m_cnt != '0) begin
      m_cnt <= m_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/rs_issue_chk.sv
module rs_issue_chk #(
  parameter int DW = 16,
  parameter int NREG = 8,
  parameter int NS = 5,
  parameter int TW = 3,
  parameter int RW = 3,
  parameter int QW = 2,
  parameter int QD = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cdb_valid,
  input logic [TW-1:0] cdb_tag,
  input logic          a_done,
  input logic          m_done,
  input logic [TW-1:0] a_tag,
  input logic          issue,
  input logic [RW-1:0] h_dst,
  input logic [TW-1:0] iss_tag,
  input logic [QW:0]   q_cnt,
  input logic          s_busy [NS+1],
  input logic          s_exec [NS+1],
  input logic [TW-1:0] qi [NREG],
  input logic [DW-1:0] regs [NREG]
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) q_cnt <= (QW+1)'(QD)); // R2
  AST_RENAME_DST: assert property (@(posedge clk) disable iff (!rst_n) issue |=> qi[$past(h_dst)] == $past(iss_tag)); // R3
  AST_BCAST_FROM_EXEC: assert property (@(posedge clk) disable iff (!rst_n) cdb_valid |-> s_busy[cdb_tag] && s_exec[cdb_tag]); // R4
  AST_MUL_FIRST: assert property (@(posedge clk) disable iff (!rst_n) (a_done && m_done) |=> cdb_valid && cdb_tag == $past(a_tag)); // R8
  AST_FREE_AT_BCAST: assert property (@(posedge clk) disable iff (!rst_n) cdb_valid |=> !s_busy[$past(cdb_tag)]); // R9

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    AST_STALE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (cdb_valid && qi[r] != cdb_tag) |=> regs[r] == $past(regs[r])); // R6
  end
endmodule

bind rs_issue_core rs_issue_chk #(
  .DW(DW), .NREG(NREG), .NS(NS), .TW(TW), .RW(RW), .QW(QW), .QD(QD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
  .a_done(a_done), .m_done(m_done), .a_tag(a_tag), .issue(issue),
  .h_dst(h_dst), .iss_tag(iss_tag), .q_cnt(q_cnt), .s_busy(s_busy),
  .s_exec(s_exec), .qi(qi), .regs(regs)
);

// File: tb/sim_rs_issue_core.sv
module sim_rs_issue_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_op = '0;
  logic [2:0]  in_dst = '0, in_src1 = '0, in_src2 = '0, rd_addr = '0;
  logic [15:0] rd_value, cdb_value;
  logic [2:0]  rd_tag, cdb_tag;
  logic        cdb_valid;

  int n_run = 0, n_fail = 0;
  bit stall_seen = 0;
  logic [15:0] gregs [8];

  always #4 clk = ~clk;

  rs_issue_core u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .rd_addr(rd_addr), .rd_value(rd_value), .rd_tag(rd_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  function automatic logic [15:0] calc(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return (b == 16'd0) ? 16'hFFFF : a / b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [2:0] d, input logic [2:0] a, input logic [2:0] b);
    while (!in_ready) begin
      stall_seen = 1;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_op = op; in_dst = d; in_src1 = a; in_src2 = b;
    gregs[d] = calc(op, gregs[a], gregs[b]);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_regs(input string req);
    for (int r = 0; r < 8; r++) begin
      rd_addr = 3'(r);
      #1;
      chk(rd_value == gregs[r], req, rd_value, gregs[r]);
      chk(rd_tag == 3'd0, req, rd_tag, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int r = 0; r < 8; r++) gregs[r] = 16'(r);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(in_ready == 1'b1, "R1", in_ready, 1);
    chk(cdb_valid == 1'b0, "R1", cdb_valid, 0);
    check_regs("R1");

    // R3/R4 add: rename then broadcast timing
    push(2'd0, 3'd7, 3'd1, 3'd2);
    rd_addr = 3'd7;
    @(negedge clk);
    chk(rd_tag == 3'd1, "R3", rd_tag, 1);
    @(negedge clk);
    chk(cdb_valid == 1'b0, "R4", cdb_valid, 0);
    @(negedge clk);
    chk(cdb_valid && cdb_tag == 3'd1, "R4", cdb_tag, 1);
    chk(cdb_value == gregs[7], "R4", cdb_value, gregs[7]);
    drain(10);

    // R4 multiply timing
    push(2'd2, 3'd6, 3'd2, 3'd3);
    drain(4);
    chk(cdb_valid == 1'b0, "R4", cdb_valid, 0);
    @(negedge clk);
    chk(cdb_valid && cdb_tag == 3'd4, "R4", cdb_tag, 4);
    chk(cdb_value == gregs[6], "R4", cdb_value, gregs[6]);
    drain(10);

    // R8 simultaneous finish: multiplier first, adder next cycle
    push(2'd2, 3'd1, 3'd2, 3'd3);
    @(negedge clk);
    push(2'd1, 3'd4, 3'd5, 3'd6);
    drain(3);
    chk(cdb_valid && cdb_tag == 3'd4, "R8", cdb_tag, 4);
    @(negedge clk);
    chk(cdb_valid && cdb_tag == 3'd1, "R8", cdb_tag, 1);
    chk(cdb_value == gregs[4], "R8", cdb_value, gregs[4]);
    drain(10);
    check_regs("R8");

    // R6 overlapping writes: add issued later wins over slower multiply
    push(2'd2, 3'd1, 3'd2, 3'd3);
    push(2'd0, 3'd1, 3'd4, 3'd5);
    drain(12);
    check_regs("R6");

    // R9 issue coincides with producer broadcast
    push(2'd2, 3'd1, 3'd2, 3'd6);
    drain(4);
    push(2'd0, 3'd3, 3'd1, 3'd0);
    drain(12);
    check_regs("R9");

    // R10 destination equals source
    push(2'd2, 3'd2, 3'd3, 3'd4);
    push(2'd0, 3'd2, 3'd2, 3'd2);
    drain(12);
    check_regs("R10");

    // R7 divide by zero gives all ones
    push(2'd3, 3'd5, 3'd6, 3'd0);
    drain(10);
    rd_addr = 3'd5;
    #1;
    chk(rd_value == 16'hFFFF, "R7", rd_value, 16'hFFFF);
    push(2'd3, 3'd6, 3'd4, 3'd7);
    push(2'd1, 3'd7, 3'd3, 3'd4);
    drain(12);
    check_regs("R7");

    // R2 burst of multiplies fills stations and queue
    stall_seen = 0;
    for (int k = 0; k < 8; k++) push(2'd2, 3'(k), 3'((k + 1) % 8), 3'((k + 3) % 8));
    chk(stall_seen == 1, "R2", stall_seen, 1);
    drain(60);
    check_regs("R2");

    // R5 random traffic against in-order model
    for (int rnd = 0; rnd < 10; rnd++) begin
      for (int k = 0; k < 30; k++) begin
        push(2'($urandom % 4), 3'($urandom % 8), 3'($urandom % 8), 3'($urandom % 8));
        if (($urandom % 4) == 0) @(negedge clk);
      end
      drain(250);
      check_regs("R5");
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule